// File: doc/BRIEF.md
# Four-Phase Handshake Frequency Halver

This block is a clocked model of a handshake element that doubles activity. It has a passive four-phase port on the a side (request in, acknowledge out) and an active four-phase port on the b side (request out, acknowledge in). For every complete return-to-zero handshake that a partner makes on the a side, the block makes exactly two complete handshakes on the b side. The rising phase of a covers one full b cycle and the rising half of a second one. The falling phase of a covers the falling half of that second b cycle.

Stages can be cascaded. The active port of one stage drives the passive port of the next, and `STAGES` sets the depth. With M stages, the b side of the last stage completes 2^M handshakes for each handshake on the a side of the first stage. The first port therefore toggles at the last port's rate divided by 2^M.

All pins are plain control wires. No data moves through the block, so it has no valid/ready interface. Back-pressure is the protocol itself: the block never moves ahead of the partner's acknowledge. Reset is synchronous and active low. Inputs are sampled on the rising clock edge, and each output is a flop.

Top module: `hsd_chain`

## Requirements
- R1: While `rst_n` is low at a clock edge, `b_req` and `a_ack` are low after that edge, and each stage returns to idle.
- R2: `b_req` rises only while `b_ack` is low, and falls only while `b_ack` is high. A change on `b_ack` is answered by at most one change of `b_req`.
- R3: In a single stage, `a_ack` goes high one clock after `b_ack` is sampled high for the second b cycle, while `a_req` is still high. It never goes high before that point.
- R4: Each complete handshake on the a port produces exactly 2^STAGES rising edges of `b_req`: two for one stage and eight for three stages.
- R5: `a_ack` goes low only after `a_req` has been sampled low and `b_ack` has been sampled low with `b_req` low. At that point `b_req` is also low.
- R6: In a single stage, when `a_req` is sampled low during the final acknowledge, `b_req` falls one clock later and `a_ack` stays high.
- R7: In a single stage, `b_req` rises one clock after `a_req` is sampled high in idle. This includes the cycle right after an acknowledge falls, so a new request that arrives at once starts without a gap.
- R8: In a chain, the active port of stage i drives the passive port of stage i+1. An environment that acknowledges the last b port after any latency always lets the first a handshake complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_req | input | 1 | Request from the active partner on the passive port |
| a_ack | output | 1 | Acknowledge to the partner on the passive port |
| b_req | output | 1 | Request issued on the active port (last stage) |
| b_ack | input | 1 | Acknowledge received on the active port (last stage) |

## Verification
The assertions check four things on every cycle at the chain ports: the b-side alternation rules, the conditions that must hold when `a_ack` changes, the reset state, and a running count of `b_req` rising edges that must equal 2^STAGES at each acknowledge. The single-stage cycle timings can only be shown by the bench's scenarios. These are the one-clock response to each input, a new request arriving in the same cycle that the acknowledge falls, and a reset during a handshake. The same holds for the three-stage chain completing its handshakes under random acknowledge latency.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_B1_UP  = 3'd1,
    S_B1_DN  = 3'd2,
    S_B2_UP  = 3'd3,
    S_ACK_UP = 3'd4,
    S_B2_DN  = 3'd5,
    S_ACK_DN = 3'd6
  } hsd_state_t;
endpackage

// File: rtl/hsd_stage.sv
module hsd_stage
  import hsd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_req,
  output logic a_ack,
  output logic b_req,
  input  logic b_ack
);
  hsd_state_t st, nxt;
  logic       b_req_q, a_ack_q;

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE:   if (a_req)  nxt = S_B1_UP;
      S_B1_UP:  if (b_ack)  nxt = S_B1_DN;
      S_B1_DN:  if (!b_ack) nxt = S_B2_UP;
      S_B2_UP:  if (b_ack)  nxt = S_ACK_UP;
      S_ACK_UP: if (!a_req) nxt = S_B2_DN;
      S_B2_DN:  if (!b_ack) nxt = S_ACK_DN;
      S_ACK_DN: nxt = a_req ? S_B1_UP : S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  // Outputs are registered from the next state so they change with it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      b_req_q <= 1'b0;
      a_ack_q <= 1'b0;
    end else begin
      st      <= nxt;
      b_req_q <= (nxt == S_B1_UP) || (nxt == S_B2_UP) || (nxt == S_ACK_UP);
      a_ack_q <= (nxt == S_ACK_UP) || (nxt == S_B2_DN);
    end
  end

  assign b_req = b_req_q;
  assign a_ack = a_ack_q;
endmodule

// File: rtl/hsd_chain.sv
module hsd_chain #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_req,
  output logic a_ack,
  output logic b_req,
  input  logic b_ack
);
  logic [STAGES:0] req_w;
  logic [STAGES:0] ack_w;

  assign req_w[0]      = a_req;
  assign a_ack         = ack_w[0];
  assign b_req         = req_w[STAGES];
  assign ack_w[STAGES] = b_ack;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    hsd_stage u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .a_req (req_w[i]),
      .a_ack (ack_w[i]),
      .b_req (req_w[i+1]),
      .b_ack (ack_w[i+1])
    );
  end
endmodule

// File: rtl/hsd_chain_chk.sv
module hsd_chain_chk #(
  parameter int STAGES = 3
) (
  input logic clk,
  input logic rst_n,
  input logic a_req,
  input logic a_ack,
  input logic b_req,
  input logic b_ack
);
  localparam int CW = STAGES + 2;
  localparam logic [CW-1:0] EXP_RISES = CW'(1) << STAGES;

  logic          breq_d, aack_d;
  logic [CW-1:0] rises;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      breq_d <= 1'b0;
      aack_d <= 1'b0;
      rises  <= '0;
    end else begin
      breq_d <= b_req;
      aack_d <= a_ack;
      if (aack_d && !a_ack)
        rises <= (b_req && !breq_d) ? CW'(1) : '0;
      else if (b_req && !breq_d)
        rises <= rises + 1'b1;
    end
  end

  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |=> (!b_req && !a_ack));

  p_breq_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_req) |-> !$past(b_ack));

  p_breq_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(b_req) |-> $past(b_ack));

  p_aack_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_ack) |-> ($past(a_req) && $past(b_ack) && b_req));

  p_two_pow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ack && !aack_d) |-> (rises == EXP_RISES));

  p_aack_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(a_ack) |-> (!$past(a_req) && !$past(b_ack) && !b_req));
endmodule

bind hsd_chain hsd_chain_chk #(.STAGES(STAGES)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .a_req (a_req),
  .a_ack (a_ack),
  .b_req (b_req),
  .b_ack (b_ack)
);

// File: tb/tb_hsd_chain.sv
module tb_hsd_chain;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Three-stage chain
  logic a_req = 1'b0, b_ack = 1'b0;
  logic a_ack, b_req;
  hsd_chain #(.STAGES(3)) dut (
    .clk(clk), .rst_n(rst_n), .a_req(a_req), .a_ack(a_ack),
    .b_req(b_req), .b_ack(b_ack));

  // Single stage
  logic s_areq = 1'b0, s_back = 1'b0;
  logic s_aack, s_breq;
  hsd_chain #(.STAGES(1)) dut1 (
    .clk(clk), .rst_n(rst_n), .a_req(s_areq), .a_ack(s_aack),
    .b_req(s_breq), .b_ack(s_back));

  // {a_req, b_ack, expected b_req, expected a_ack}
  localparam int NV = 25;
  localparam logic [3:0] VEC [NV] = '{
    4'b0000, 4'b1010, 4'b1010, 4'b1100, 4'b1100,
    4'b1010, 4'b1111, 4'b1111, 4'b0101, 4'b0101,
    4'b0000, 4'b0000, 4'b1010, 4'b1100, 4'b1010,
    4'b1111, 4'b0101, 4'b0000, 4'b1010, 4'b1100,
    4'b1010, 4'b1111, 4'b0101, 4'b0000, 4'b0000
  };

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Random-latency acknowledger on the last port of the chain (R8)
  logic ack_en = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (ack_en && b_req && !b_ack) begin
        repeat ($urandom_range(0, 3)) @(negedge clk);
        b_ack = 1'b1;
      end else if (ack_en && !b_req && b_ack) begin
        repeat ($urandom_range(0, 3)) @(negedge clk);
        b_ack = 1'b0;
      end
    end
  end

  // Count rising edges of the chain's b_req
  int   rise_cnt = 0;
  logic breq_prev = 1'b0;
  always @(negedge clk) begin
    if (b_req && !breq_prev) rise_cnt++;
    breq_prev <= b_req;
  end

  task automatic summary_and_end();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary_and_end();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset single", {s_breq, s_aack}, 2'b00);
    chk("R1 reset chain", {b_req, a_ack}, 2'b00);
    rst_n = 1'b1;

    // Table walk, single stage: R2 R3 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      s_areq = VEC[i][3];
      s_back = VEC[i][2];
      @(negedge clk);
      chk($sformatf("R2/R3/R5/R6/R7 step %0d", i), {s_breq, s_aack}, VEC[i][1:0]);
    end

    // R1: reset in mid-handshake
    s_areq = 1'b1; s_back = 1'b0;
    @(negedge clk);
    chk("R7 rise before reset", {s_breq, s_aack}, 2'b10);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid handshake", {s_breq, s_aack}, 2'b00);
    s_areq = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {s_breq, s_aack}, 2'b00);

    // Chain of three with random acknowledge latency: R4 R8 R5
    ack_en = 1'b1;
    for (int h = 0; h < 4; h++) begin
      rise_cnt = 0;
      a_req = 1'b1;
      while (!a_ack) @(negedge clk);
      chk_int($sformatf("R4 R8 rises at ack, handshake %0d", h), rise_cnt, 8);
      a_req = 1'b0;
      while (a_ack) @(negedge clk);
      chk_int($sformatf("R4 rises after release, handshake %0d", h), rise_cnt, 8);
      chk($sformatf("R5 chain idle, handshake %0d", h), {b_req, a_ack}, 2'b00);
      repeat (h) @(negedge clk);
    end
    summary_and_end();
  end
endmodule